// File: doc/BRIEF.md
# Addressed Parallel Register Bus Master

This block issues single register accesses on a parallel bus that reaches a set of remote boards. Each access names one of sixteen boards and one of four 8-bit registers on that board, and is either a write or a read. The master places a combined 6-bit address and a direction level on the bus. For writes it also places the data. It then pulses an active-low data strobe for a fixed number of clock cycles. Raising the strobe again ends the access.

A client raises `reqValid` for one cycle while the block is idle, with the board, register, direction and write data. The block reports `busy` for the whole access and pulses `done` for one cycle when the access ends. After a read, `rdData` holds the byte sampled from the bus. The data bus is split into an outgoing value, an output enable and an incoming value, so the pad logic can tri-state it.

Top module: `regbus_master`

## Requirements
- R1: After reset, `busStrobeN` is 1, `busy`, `done`, `busDataOe` and `busWrRd` are 0, and `busAddr` and `rdData` are 0.
- R2: During an access, `busAddr` carries the board number in bits 5:2 and the register index in bits 1:0.
- R3: For a write (`reqWrite`=1), `busWrRd` is 1 and `busDataOut` equals the request data with `busDataOe`=1 in every busy cycle.
- R4: For a read (`reqWrite`=0), `busWrRd` is 0, `busDataOe` stays 0 throughout, and `rdData` takes the value of `busDataIn` present during the second (last) low cycle of the strobe.
- R5: Every access drives `busStrobeN` low for exactly STROBE_LEN (default 2) consecutive cycles, and only while `busy` is 1.
- R6: `busAddr` and `busWrRd` are stable from one cycle before the strobe falls until one cycle after it rises.
- R7: An access accepted at a clock edge shows `busy` for STROBE_LEN+2 cycles: one setup cycle, STROBE_LEN strobe cycles and one hold cycle. `done` is then 1 for exactly one cycle with `busy` at 0.
- R8: A request raised while `busy` is 1 is ignored. It starts no strobe and changes neither `busAddr` nor the access in progress.
- R9: `rdData` keeps the last read value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqBoard | input | 4 | Target board number |
| reqReg | input | 2 | Target register index |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqData | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdData | output | 8 | Last captured read byte |
| busAddr | output | 6 | Bus address {board, register} |
| busWrRd | output | 1 | Bus direction, 1 = write |
| busStrobeN | output | 1 | Active-low data strobe |
| busDataOut | output | 8 | Data driven onto the bus |
| busDataOe | output | 1 | Drive enable for the data bus |
| busDataIn | input | 8 | Data sampled from the bus |

## Verification
The bound checker watches the bus timing on every cycle. It checks that the strobe low time never exceeds STROBE_LEN and is exactly STROBE_LEN when it ends, that the strobe is low only while busy, and that address and direction hold steady around the strobe. It also checks that the data bus stays released during reads and is driven during write strobes, and that `done` is a single-cycle pulse outside busy. Only the bench scenarios can show the remaining points: the address packing of particular requests, which strobe cycle supplies the read byte, the dropping of requests made while busy, and the persistence of `rdData` across writes.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } accState_t;

  typedef struct packed {
    logic load;       // take a new request into the bus registers
    logic capture;    // sample incoming bus data
    logic strobeLow;  // strobe is asserted this cycle
    logic active;     // an access is in progress
  } ctlStrobe_t;
endpackage

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
#(
  parameter int STROBE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (STROBE_LEN > 1) ? $clog2(STROBE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_LEN - 1);

  accState_t        state;
  logic [CNT_W-1:0] lowCnt;
  logic             doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lowCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) state <= ST_SETUP;
        end
        ST_SETUP: begin
          state  <= ST_STROBE;
          lowCnt <= '0;
        end
        ST_STROBE: begin
          if (lowCnt == LAST_CNT) state <= ST_HOLD;
          else lowCnt <= lowCnt + 1'b1;
        end
        ST_HOLD: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && reqValid;
    ctl.capture   = (state == ST_STROBE) && (lowCnt == LAST_CNT);
    ctl.strobeLow = (state == ST_STROBE);
    ctl.active    = (state != ST_IDLE);
  end

  assign busy = ctl.active;
  assign done = doneQ;
endmodule

// File: rtl/regbus_dpath.sv
module regbus_dpath
  import regbus_pkg::*;
#(
  parameter int BOARD_W = 4,
  parameter int REG_W   = 2,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctlStrobe_t                 ctl,
  input  logic [BOARD_W-1:0]         reqBoard,
  input  logic [REG_W-1:0]           reqReg,
  input  logic                       reqWrite,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [BOARD_W+REG_W-1:0]   busAddr,
  output logic                       busWrRd,
  output logic                       busStrobeN,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  output logic [DATA_W-1:0]          rdData
);
  localparam int ADDR_W = BOARD_W + REG_W;

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ   <= '0;
      writeQ  <= 1'b0;
      wrDataQ <= '0;
    end else if (ctl.load) begin
      addrQ   <= {reqBoard, reqReg};
      writeQ  <= reqWrite;
      wrDataQ <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdDataQ <= '0;
    else if (ctl.capture && !writeQ) rdDataQ <= busDataIn;
  end

  assign busAddr    = addrQ;
  assign busWrRd    = writeQ;
  assign busDataOut = wrDataQ;
  assign busDataOe  = ctl.active && writeQ;
  assign busStrobeN = ~ctl.strobeLow;
  assign rdData     = rdDataQ;
endmodule

// File: rtl/regbus_master.sv
module regbus_master
  import regbus_pkg::*;
#(
  parameter int BOARD_W    = 4,
  parameter int REG_W      = 2,
  parameter int DATA_W     = 8,
  parameter int STROBE_LEN = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  input  logic [BOARD_W-1:0]       reqBoard,
  input  logic [REG_W-1:0]         reqReg,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        reqData,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  output logic [BOARD_W+REG_W-1:0] busAddr,
  output logic                     busWrRd,
  output logic                     busStrobeN,
  output logic [DATA_W-1:0]        busDataOut,
  output logic                     busDataOe,
  input  logic [DATA_W-1:0]        busDataIn
);
  ctlStrobe_t ctl;

  regbus_ctrl #(.STROBE_LEN(STROBE_LEN)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  regbus_dpath #(.BOARD_W(BOARD_W), .REG_W(REG_W), .DATA_W(DATA_W)) i_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .reqBoard   (reqBoard),
    .reqReg     (reqReg),
    .reqWrite   (reqWrite),
    .reqData    (reqData),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busWrRd    (busWrRd),
    .busStrobeN (busStrobeN),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .rdData     (rdData)
  );
endmodule

// File: rtl/regbus_master_chk.sv
module regbus_master_chk #(
  parameter int ADDR_W     = 6,
  parameter int STROBE_LEN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrRd,
  input logic              busStrobeN,
  input logic              busDataOe
);
  logic [7:0] lowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowRun <= '0;
    else if (!busStrobeN) lowRun <= (lowRun == 8'hFF) ? lowRun : lowRun + 8'd1;
    else lowRun <= '0;
  end

  // R5
  strobe_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busStrobeN |-> (lowRun < 8'(STROBE_LEN)));
  // R5
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busStrobeN) |-> (lowRun == 8'(STROBE_LEN)));
  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busStrobeN |-> busy);
  // R6
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busStrobeN |-> ($stable(busAddr) && $stable(busWrRd)));
  // R6
  addr_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busStrobeN) |=> ($stable(busAddr) && $stable(busWrRd)));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busWrRd |-> !busDataOe);
  // R3
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busStrobeN && busWrRd) |-> busDataOe);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind regbus_master regbus_master_chk #(
  .ADDR_W(BOARD_W + REG_W),
  .STROBE_LEN(STROBE_LEN)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .busAddr    (busAddr),
  .busWrRd    (busWrRd),
  .busStrobeN (busStrobeN),
  .busDataOe  (busDataOe)
);

// File: tb/test_regbus_master.sv
module test_regbus_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [3:0] reqBoard = '0;
  logic [1:0] reqReg = '0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqData = '0;
  logic       busy, done, busWrRd, busStrobeN, busDataOe;
  logic [7:0] rdData, busDataOut;
  logic [5:0] busAddr;
  logic [7:0] busDataIn = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  regbus_master i_regbus_master (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqBoard(reqBoard),
    .reqReg(reqReg), .reqWrite(reqWrite), .reqData(reqData), .busy(busy),
    .done(done), .rdData(rdData), .busAddr(busAddr), .busWrRd(busWrRd),
    .busStrobeN(busStrobeN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full access. Drives a request at a falling edge, then samples 7 falling edges.
  // If stray is set, a second request is raised during the strobe (R8).
  task automatic doAccess(input logic [3:0] brd, input logic [1:0] rg, input bit wr,
                          input logic [7:0] wd, input logic [7:0] rdExp, input bit stray);
    int lowCnt = 0;
    int busyCnt = 0;
    int doneAt = -1;
    bit addrOk = 1, dirOk = 1, oeOk = 1, dataOk = 1;
    logic [7:0] rdBefore = rdData;
    @(negedge clk);
    reqValid = 1; reqBoard = brd; reqReg = rg; reqWrite = wr; reqData = wd;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (i == 1) begin
        reqValid = 0; reqBoard = ~brd; reqReg = ~rg; reqWrite = ~wr; reqData = ~wd;
      end
      if (i == 2) begin busDataIn = ~rdExp; if (stray) reqValid = 1; end
      if (i == 3) begin busDataIn = rdExp; reqValid = 0; end
      if (i == 4) busDataIn = rdExp ^ 8'h5A;
      if (!busStrobeN) lowCnt++;
      if (busy) begin
        busyCnt++;
        if (busAddr != {brd, rg}) addrOk = 0;
        if (busWrRd != wr) dirOk = 0;
        if (busDataOe != wr) oeOk = 0;
        if (wr && busDataOut != wd) dataOk = 0;
      end
      if (done && doneAt < 0) doneAt = i;
    end
    check(addrOk, "R2 address packing", busAddr, {brd, rg});
    check(dirOk, wr ? "R3 direction high" : "R4 direction low", busWrRd, wr);
    check(oeOk, wr ? "R3 drive enable" : "R4 bus released", busDataOe, wr);
    if (wr) check(dataOk, "R3 write data", busDataOut, wd);
    check(lowCnt == 2, "R5 strobe low cycles", lowCnt, 2);
    check(busyCnt == 4, "R7 busy cycles", busyCnt, 4);
    check(doneAt == 5, "R7 done timing", doneAt, 5);
    if (wr) check(rdData == rdBefore, "R9 rdData kept on write", rdData, rdBefore);
    else    check(rdData == rdExp, "R4 read capture on second low cycle", rdData, rdExp);
    if (stray) check(busAddr == {brd, rg} && !busy, "R8 request during busy ignored",
                     busAddr, {brd, rg});
  endtask

  task automatic testReset();
    check(busStrobeN == 1 && !busy && !done && !busDataOe && !busWrRd, "R1 reset controls",
          {busStrobeN, busy, done, busDataOe, busWrRd}, 5'b10000);
    check(busAddr == 0 && rdData == 0, "R1 reset data", {busAddr, rdData}, 0);
  endtask

  task automatic testIdleQuiet();
    int lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!busStrobeN || busy) lows++;
    end
    check(lows == 0, "R8 no extra access after stray request", lows, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testReset();
    doAccess(4'hA, 2'd3, 1, 8'h3C, 8'h00, 0);   // R3 write
    doAccess(4'h5, 2'd1, 0, 8'h00, 8'hC7, 0);   // R4 read
    doAccess(4'hF, 2'd0, 1, 8'hE1, 8'h00, 0);   // R9 write keeps rdData
    doAccess(4'h0, 2'd2, 0, 8'h00, 8'h19, 1);   // R8 stray request while busy
    testIdleQuiet();
    doAccess(4'h3, 2'd3, 1, 8'h81, 8'h00, 1);   // R8 stray during write
    testIdleQuiet();
    doAccess(4'hC, 2'd2, 0, 8'h00, 8'hFF, 0);   // R4 read all ones
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule